// File: doc/BRIEF.md
# Windowed Watchdog Timer with Two-Step Service Key

This block is a watchdog timer that sits on a simple synchronous write bus with two write targets: a control register and an arm register. Once software programs a non-zero rate, a down-counter counts prescaled ticks. If the count runs out, the block asks the system for a reset. Software keeps the system alive by writing a two-byte key to the arm register: first 0x55, then 0xAA.

In window mode, a service write is accepted only during the last quarter of the period. A wrong byte, or a key written too early, is treated as a software fault and requests a reset at once. A control bit can force a reset request directly, and a mask bit holds back every reset request. The reset request is a single-cycle pulse. After each pulse the counter restarts from the full period. The tick that paces the counter comes from an external prescaler.

Top module: `wdg_window_top`

## Requirements
- R1: After reset the watchdog is off: the rate is 0, `rst_req` is low, and no pulse appears while nothing is written.
- R2: Writes with `wr_sel`=0 go to the control register, with rate in bits [2:0], window enable in bit 3, force in bit 4 and mask in bit 5. Writes with `wr_sel`=1 go to the arm register. Every control write reloads the counter with the period of the new rate and restarts the key sequence at 0x55.
- R3: With rate 0 the counter is stopped: no timeout occurs and arm writes have no effect, including wrong keys.
- R4: With rate n (1 to 7) the period P is 2^(BASE_LOG2+STEP_LOG2*n) ticks. With `tick_en` held high, `rst_req` is high for exactly one cycle, P cycles after the cycle that loaded the counter, and the counter then reloads to P.
- R5: While `tick_en` is low the counter holds its value.
- R6: Writing 0x55 and then 0xAA to the arm register reloads the counter to the full period without a reset request. The sequence then expects 0x55 again.
- R7: While the watchdog runs, any arm write that is not the expected key raises `rst_req` in the next cycle. It also reloads the counter and resets the sequence to expect 0x55.
- R8: In window mode, an arm write is accepted only when the remaining count is at most P/4. An earlier write is a violation, as in R7. Without window mode, the key is accepted at any count.
- R9: A control write with bit 4 set raises a one-cycle `rst_req`. The bit is not stored.
- R10: While the stored mask bit is set, no cause produces `rst_req`. A write is judged by the mask value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable, one tick per cycle when high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 arm |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | Single-cycle system reset request |

## Verification
The checker watches several properties on every cycle:
- the mask keeps `rst_req` low;
- a stopped watchdog stays quiet unless forced;
- the counter is zero whenever the rate is 0;
- the counter steps down by exactly one per tick and holds without a tick;
- the key sequence rewinds after a service.

Only the bench scenarios can show the exact timeout distance for several rates and the reload after a timeout. The same holds for the accepted and rejected key orders, the exact window boundary at P/4 against one count earlier, and the one-shot nature of the force bit.

// File: rtl/wdg_pkg.sv
// Shared constants and types for the windowed watchdog.
// Assumes an 8-bit write bus and a 3-bit rate field.
package wdg_pkg;
    localparam int RATE_W = 3;
    localparam int NRATE  = 1 << RATE_W;
    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic { SEL_CTRL = 1'b0, SEL_ARM = 1'b1 } wdg_sel_e;

    // Control write layout, bits [5:0] of the bus word.
    typedef struct packed {
        logic              mask;
        logic              force_rst;
        logic              window;
        logic [RATE_W-1:0] rate;
    } wdg_ctrl_t;
endpackage

// File: rtl/wdg_ctrl_reg.sv
// Control register: stores rate, window enable and mask.
// Decodes the self-clearing force bit. Assumes wr_ctrl is
// already qualified by the bus strobe and target select.
module wdg_ctrl_reg
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [7:0]        wr_data,
    output logic [RATE_W-1:0] rate_q,
    output logic              window_q,
    output logic              mask_q,
    output logic [RATE_W-1:0] rate_new,
    output logic              force_pulse
);
    wdg_ctrl_t cfg;

    // Purpose: view the bus word as control fields.
    always_comb begin
        cfg         = wdg_ctrl_t'(wr_data[5:0]);
        rate_new    = cfg.rate;
        force_pulse = wr_ctrl & cfg.force_rst;
    end

    // Purpose: hold the stored control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= '0;
            window_q <= 1'b0;
            mask_q   <= 1'b0;
        end else if (wr_ctrl) begin
            rate_q   <= cfg.rate;
            window_q <= cfg.window;
            mask_q   <= cfg.mask;
        end
    end
endmodule

// File: rtl/wdg_counter.sv
// Timeout down-counter. A period table is built per rate
// (rate 0 = stopped). Flags timeout on the tick that ends the
// period and reports whether the final quarter is reached.
// Assumes at most one tick per clock.
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 8,
    parameter int STEP_LOG2 = 2,
    parameter int CW        = BASE_LOG2 + STEP_LOG2 * (NRATE - 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [RATE_W-1:0] rate_q,
    input  logic [RATE_W-1:0] rate_new,
    input  logic              cfg_load,
    input  logic              rewind,
    output logic [CW-1:0]     cnt,
    output logic              active,
    output logic              win_open,
    output logic              timeout
);
    logic [CW-1:0] period_tab [NRATE];
    logic [CW-1:0] period_cur;

    // One period entry per rate value.
    for (genvar g = 0; g < NRATE; g++) begin : g_period
        if (g == 0) begin : g_off
            assign period_tab[g] = '0;
        end else begin : g_on
            assign period_tab[g] = {{(CW-1){1'b0}}, 1'b1} << (BASE_LOG2 + STEP_LOG2 * g);
        end
    end

    // Purpose: derive status of the running count.
    always_comb begin
        period_cur = period_tab[rate_q];
        active     = (rate_q != '0);
        timeout    = active & tick_en & (cnt == {{(CW-1){1'b0}}, 1'b1});
        win_open   = (cnt <= (period_cur >> 2));
    end

    // Purpose: load, reload or decrement the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cfg_load) begin
            cnt <= period_tab[rate_new];
        end else if (rewind || timeout) begin
            cnt <= period_cur;
        end else if (active && tick_en) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wdg_key_seq.sv
// Two-step service key checker. Judges each arm write against
// the expected key and the window. Reports a good service or a
// violation in the same cycle. Ignores arm writes while the
// watchdog is stopped.
module wdg_key_seq
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_arm,
    input  logic [7:0] wr_data,
    input  logic       restart,
    input  logic       active,
    input  logic       window_q,
    input  logic       win_open,
    output logic       exp_second,
    output logic       svc,
    output logic       violation
);
    logic arm_live, early, bad_key;

    // Purpose: classify the current arm write.
    always_comb begin
        arm_live  = wr_arm & active;
        early     = window_q & ~win_open;
        bad_key   = exp_second ? (wr_data != KEY_SECOND) : (wr_data != KEY_FIRST);
        violation = arm_live & (early | bad_key);
        svc       = arm_live & ~early & ~bad_key & exp_second;
    end

    // Purpose: track which key byte comes next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_second <= 1'b0;
        end else if (restart || violation || svc) begin
            exp_second <= 1'b0;
        end else if (arm_live) begin
            exp_second <= 1'b1;
        end
    end
endmodule

// File: rtl/wdg_window_top.sv
// Windowed watchdog top. Decodes bus writes, joins the control
// register, counter and key checker, and registers the reset
// request as a one-cycle pulse. Assumes tick_en comes from an
// external prescaler.
module wdg_window_top
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 8,
    parameter int STEP_LOG2 = 2,
    localparam int CW       = BASE_LOG2 + STEP_LOG2 * (NRATE - 1) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       rst_req
);
    logic              wr_ctrl, wr_arm;
    logic [RATE_W-1:0] rate_q, rate_new;
    logic              window_q, mask_q, force_pulse;
    logic [CW-1:0]     cnt;
    logic              active, win_open, timeout;
    logic              exp_second, svc, violation;

    // Purpose: split the write strobe by target.
    always_comb begin
        wr_ctrl = wr_en & (wr_sel == SEL_CTRL);
        wr_arm  = wr_en & (wr_sel == SEL_ARM);
    end

    wdg_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
        .rate_q(rate_q), .window_q(window_q), .mask_q(mask_q),
        .rate_new(rate_new), .force_pulse(force_pulse)
    );

    wdg_counter #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_q(rate_q),
        .rate_new(rate_new), .cfg_load(wr_ctrl), .rewind(svc | violation),
        .cnt(cnt), .active(active), .win_open(win_open), .timeout(timeout)
    );

    wdg_key_seq u_key (
        .clk(clk), .rst_n(rst_n), .wr_arm(wr_arm), .wr_data(wr_data),
        .restart(wr_ctrl), .active(active), .window_q(window_q),
        .win_open(win_open), .exp_second(exp_second), .svc(svc),
        .violation(violation)
    );

    // Purpose: register the masked reset request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= (timeout | violation | force_pulse) & ~mask_q;
        end
    end
endmodule

// File: rtl/wdg_window_checker.sv
// Cycle-level properties of the windowed watchdog, bound to the top.
module wdg_window_checker #(
    parameter int CW = 23
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic          wr_en,
    input logic          wr_sel,
    input logic [7:0]    wr_data,
    input logic          rst_req,
    input logic [2:0]    rate_q,
    input logic          mask_q,
    input logic [CW-1:0] cnt,
    input logic          exp_second,
    input logic          svc
);
    a_r10_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |=> !rst_req);

    a_r3_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_q == 3'd0 && !(wr_en && !wr_sel && wr_data[4])) |=> !rst_req);

    a_r3_stopped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_q == 3'd0) |-> (cnt == '0));

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && tick_en && rate_q != 3'd0 && cnt > 1) |=> (cnt == $past(cnt) - 1'b1));

    a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick_en) |=> $stable(cnt));

    a_r6_seq_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> !exp_second);
endmodule

bind wdg_window_top wdg_window_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rst_req(rst_req),
    .rate_q(rate_q), .mask_q(mask_q), .cnt(cnt),
    .exp_second(exp_second), .svc(svc)
);

// File: tb/test_wdg_window_top.sv
`timescale 1ns/1ps
module test_wdg_window_top;
    localparam int BASE = 4;
    localparam int STEP = 1;
    localparam int P1 = 1 << (BASE + STEP * 1);
    localparam int P2 = 1 << (BASE + STEP * 2);
    localparam int P3 = 1 << (BASE + STEP * 3);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rst_req;

    int n_run = 0;
    int n_fail = 0;
    logic last_pulse;

    always #10 clk = ~clk;

    wdg_window_top #(.BASE_LOG2(BASE), .STEP_LOG2(STEP)) i_wdg_window_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rst_req(rst_req)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One write at the next edge; last_pulse holds rst_req just after it.
    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        last_pulse = rst_req;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Count edges until a pulse, then confirm it lasts one cycle.
    task automatic measure(input int exp, input string tag);
        int c = 0;
        do begin
            @(posedge clk); #1;
            c++;
        end while (!rst_req && c < exp + 50);
        check(c == exp, tag, c, exp);
        @(posedge clk); #1;
        check(rst_req == 1'b0, {tag, " one-cycle"}, rst_req, 0);
    endtask

    task automatic quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (rst_req) seen++;
        end
        check(seen == 0, tag, seen, 0);
    endtask

    task automatic t_reset();
        check(rst_req == 1'b0, "R1 reset level", rst_req, 0);
        quiet(200, "R1 idle after reset");
    endtask

    task automatic t_stopped();
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h12);
        check(last_pulse == 1'b0, "R3 arm ignored when stopped", last_pulse, 0);
        quiet(300, "R3 no timeout when stopped");
    endtask

    task automatic t_timeout();
        wr(1'b0, 8'h01);
        measure(P1, "R4 rate1 period");
        measure(P1 - 1, "R4 reload after timeout");
        wr(1'b0, 8'h02);
        measure(P2, "R4 rate2 period");
        wr(1'b0, 8'h03);
        measure(P3, "R2 R4 rate3 period after reprogram");
    endtask

    task automatic t_hold();
        tick_en = 1'b0;
        wr(1'b0, 8'h01);
        quiet(100, "R5 hold without tick");
        tick_en = 1'b1;
        measure(P1, "R5 resumes full period");
    endtask

    task automatic t_service();
        wr(1'b0, 8'h01);
        idle(10);
        wr(1'b1, 8'h55);
        check(last_pulse == 1'b0, "R6 first key accepted", last_pulse, 0);
        wr(1'b1, 8'hAA);
        check(last_pulse == 1'b0, "R6 second key accepted", last_pulse, 0);
        measure(P1, "R6 service reloads full period");
    endtask

    task automatic t_badkey();
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h00);
        check(last_pulse == 1'b1, "R7 wrong first key", last_pulse, 1);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h33);
        check(last_pulse == 1'b1, "R7 wrong second key", last_pulse, 1);
        wr(1'b1, 8'hAA);
        check(last_pulse == 1'b1, "R7 sequence restarted at 0x55", last_pulse, 1);
        wr(1'b1, 8'h55);
        wr(1'b0, 8'h01);
        wr(1'b1, 8'hAA);
        check(last_pulse == 1'b1, "R2 control write restarts sequence", last_pulse, 1);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
        check(last_pulse == 1'b0, "R7 recovery service", last_pulse, 0);
        measure(P1, "R7 period after recovery");
    endtask

    task automatic t_window();
        wr(1'b0, 8'h09);
        idle(P1 - P1 / 4 - 1);
        wr(1'b1, 8'h55);
        check(last_pulse == 1'b1, "R8 one count before window", last_pulse, 1);
        idle(P1 - P1 / 4);
        wr(1'b1, 8'h55);
        check(last_pulse == 1'b0, "R8 key at window edge", last_pulse, 0);
        wr(1'b1, 8'hAA);
        check(last_pulse == 1'b0, "R8 second key in window", last_pulse, 0);
        measure(P1, "R8 windowed service reload");
    endtask

    task automatic t_force();
        wr(1'b0, 8'h11);
        check(last_pulse == 1'b1, "R9 force pulse", last_pulse, 1);
        measure(P1, "R9 force one cycle then timeout");
        wr(1'b0, 8'h10);
        check(last_pulse == 1'b1, "R9 force while stopped", last_pulse, 1);
        quiet(300, "R9 force bit not stored");
    endtask

    task automatic t_mask();
        wr(1'b0, 8'h21);
        quiet(P1 * 3, "R10 timeout masked");
        wr(1'b1, 8'h77);
        check(last_pulse == 1'b0, "R10 bad key masked", last_pulse, 0);
        wr(1'b0, 8'h31);
        check(last_pulse == 1'b0, "R10 force masked", last_pulse, 0);
        wr(1'b0, 8'h01);
        measure(P1, "R10 unmasked timeout");
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_stopped();
        t_timeout();
        t_hold();
        t_service();
        t_badkey();
        t_window();
        t_force();
        t_mask();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule